// File: doc/BRIEF.md
# Register-Mapped Serial Port With Split Interrupts

This block is a small asynchronous serial port on a 32-bit register bus with plain read and write strobes. Software writes one byte at a time into a single transmit holding slot. The byte then moves into a shifter that sends it as a start bit, eight data bits (LSB first) and one stop bit. The receiver watches the line and captures complete frames into a single receive slot. No parity is used and no flow-control lines exist. An integer divider sets the length of one serial bit as a raw count of input clocks.

Three interrupt lines come out of the block: one for received bytes, one for transmit progress, and a shared line for both overrun conditions. Each interrupt cause has a sticky flag and an enable bit. Software clears a flag by writing a 1 to it. The bus has no back-pressure: every access completes in the cycle its strobe is high. Flow control toward the transmit slot is the job of software, which polls the buffer-full status bit. Toward the receive slot, back-pressure is replaced by an overrun flag: a frame that arrives while the slot is occupied is dropped.

Top module: `serial_port_core`

## Requirements
- R1: After reset every register reads zero, `txd` is high and all three interrupt outputs are low.
- R2: The register word index is `bus_addr[4:2]`: 0 data, 1 status, 2 control, 3 interrupt flags, 4 divider. Control keeps 6 bits (bit0 tx enable, bit1 rx enable, bit2 tx irq enable, bit3 rx irq enable, bit4 tx-overrun irq enable, bit5 rx-overrun irq enable). The divider keeps 21 bits. Both read back what was written, masked to those widths. Unused indices read zero.
- R3: A data write with tx enabled and the holding slot empty fills the slot. The shifter takes the byte on the next clock, and `txd` goes low from that edge. Each bit of start, data bits 0..7 and stop lasts exactly the effective divider in clocks. The next byte can start one clock after the stop bit ends.
- R4: Status bit0 is high from the data write until the shifter takes the byte. Interrupt flag bit0 sets when the byte is taken. `irq_tx` is flag bit0 AND control bit2.
- R5: A data write while status bit0 is set drops the byte and sets flag bit2, which status bit2 mirrors. `irq_ovr` includes flag bit2 AND control bit4.
- R6: A frame with a high stop bit, received while rx is enabled and the slot is empty, goes to the data register (low 8 bits). It sets status bit1 and flag bit1. `irq_rx` is flag bit1 AND control bit3.
- R7: A read of the data register clears status bit1 and leaves flag bit1 as it is.
- R8: A frame that completes while status bit1 is set is discarded. The data register keeps the old byte, and flag bit3 sets (status bit3 mirrors it). `irq_ovr` includes flag bit3 AND control bit5.
- R9: Writing 1 to a bit of the flag register clears that flag, and writing 0 leaves it. Writing 1 to status bits 2 or 3 clears the matching overrun flag. A flag that is set and cleared in the same cycle stays set.
- R10: A divider value below 16 behaves as 16 for both directions. The register still reads back the value that was written.
- R11: Clearing control bit0 returns `txd` high on the next clock, aborts the frame and empties the holding slot. Data writes while bit0 is clear are ignored and raise no overrun.
- R12: A start bit must still be low half a bit period after its falling edge, or it is ignored. With control bit1 clear, no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; a read of data is destructive for status bit1 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line, idles high |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_ovr | output | 1 | Shared overrun interrupt |

## Verification
The bench keeps a time-based model of the transmit line: it computes each expected line level from the cycle a byte was taken and the effective divider. A shifter that is off by one clock per bit, or that drops the one-cycle gap between frames, shows up as a line mismatch within a few cycles. Writes aimed at a full slot are made right after a byte is taken and while one is still held. A design that judges fullness after the take would accept the third byte and send three frames instead of two. On the receive side, the bench sends a glitch shorter than half a bit, which a receiver without start confirmation would turn into a spurious byte. It also sends a second frame into an unread slot, where a design that overwrites would change the data register. Divider values under 16 and a mid-frame disable catch a missing clamp and a shifter that keeps driving after the enable is cleared.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int DATA_BITS = 8;
  localparam int FRAME_LEN = DATA_BITS + 2;
  localparam int CTRL_W    = 6;
  localparam int FLAG_W    = 4;

  // register word indices
  localparam int REG_DATA = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CTRL = 2;
  localparam int REG_INTS = 3;
  localparam int REG_DIV  = 4;

  // control bits
  localparam int C_TX_EN   = 0;
  localparam int C_RX_EN   = 1;
  localparam int C_TX_IE   = 2;
  localparam int C_RX_IE   = 3;
  localparam int C_TXO_IE  = 4;
  localparam int C_RXO_IE  = 5;

  // flag bits
  localparam int F_TX  = 0;
  localparam int F_RX  = 1;
  localparam int F_TXO = 2;
  localparam int F_RXO = 3;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/sp_tx.sv
module sp_tx import sp_pkg::*; #(
  parameter int DIV_W = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [DIV_W-1:0]     div,
  input  logic                 hold_full,
  input  logic [DATA_BITS-1:0] hold_byte,
  output logic                 take,
  output logic                 txd
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic                 busy;
  logic [IDX_W-1:0]     idx;
  logic [DIV_W-1:0]     cnt;
  logic [FRAME_LEN-1:0] frame;

  assign take = en && !busy && hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      idx   <= '0;
      cnt   <= '0;
      frame <= '1;
    end else if (!en) begin
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (take) begin
      busy  <= 1'b1;
      frame <= {1'b1, hold_byte, 1'b0};
      txd   <= 1'b0;
      idx   <= '0;
      cnt   <= div - 1'b1;
    end else if (busy) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (idx == LAST) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
        txd <= frame[idx + 1'b1];
        cnt <= div - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_rx.sv
module sp_rx import sp_pkg::*; #(
  parameter int DIV_W = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [DIV_W-1:0]     div,
  input  logic                 rxd,
  output logic                 done,
  output logic [DATA_BITS-1:0] byte_out
);
  localparam int BIT_W = $clog2(DATA_BITS);

  logic             s1, s2, s3;
  rx_state_t        state;
  logic [DIV_W-1:0] cnt;
  logic [BIT_W-1:0] nbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      nbit     <= '0;
      done     <= 1'b0;
      byte_out <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: if (s3 && !s2) begin
            state <= RX_START;
            cnt   <= (div >> 1) - 1'b1;
          end
          RX_START: if (cnt != '0) cnt <= cnt - 1'b1;
            else if (!s2) begin
              state <= RX_DATA;
              cnt   <= div - 1'b1;
              nbit  <= '0;
            end else state <= RX_IDLE;
          RX_DATA: if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              byte_out <= {s2, byte_out[DATA_BITS-1:1]};
              cnt      <= div - 1'b1;
              nbit     <= nbit + 1'b1;
              if (nbit == BIT_W'(DATA_BITS - 1)) state <= RX_STOP;
            end
          default: if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              done  <= s2;
              state <= RX_IDLE;
            end
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core import sp_pkg::*; #(
  parameter int DIV_W   = 21,
  parameter int MIN_DIV = 16,
  parameter int ADDR_W  = 5,
  parameter int BUS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_ovr
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0]     sel;
  logic                 sel_data, sel_stat, sel_ctrl, sel_ints, sel_div;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [DIV_W-1:0]     div_q, eff_div;
  logic [DATA_BITS-1:0] hold_q, rx_data, rx_byte;
  logic                 hold_full, rx_full;
  logic [FLAG_W-1:0]    flags_q, fl_set, fl_clr;
  logic                 tx_take, rx_done, data_wr, tx_ovr_ev, rx_ovr_ev, rx_ev;
  logic                 unused_bits;

  assign sel      = bus_addr[ADDR_W-1:2];
  assign sel_data = (sel == SEL_W'(REG_DATA));
  assign sel_stat = (sel == SEL_W'(REG_STAT));
  assign sel_ctrl = (sel == SEL_W'(REG_CTRL));
  assign sel_ints = (sel == SEL_W'(REG_INTS));
  assign sel_div  = (sel == SEL_W'(REG_DIV));
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:DIV_W]};

  assign eff_div = (div_q < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (sel_div)  div_q  <= bus_wdata[DIV_W-1:0];
    end
  end

  // transmit holding slot
  assign data_wr   = bus_wr && sel_data && ctrl_q[C_TX_EN];
  assign tx_ovr_ev = data_wr && hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (!ctrl_q[C_TX_EN]) begin
      hold_full <= 1'b0;
    end else if (data_wr && !hold_full) begin
      hold_full <= 1'b1;
      hold_q    <= bus_wdata[DATA_BITS-1:0];
    end else if (tx_take) begin
      hold_full <= 1'b0;
    end
  end

  sp_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[C_TX_EN]), .div(eff_div),
    .hold_full(hold_full), .hold_byte(hold_q), .take(tx_take), .txd(txd)
  );

  sp_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[C_RX_EN]), .div(eff_div),
    .rxd(rxd), .done(rx_done), .byte_out(rx_byte)
  );

  // receive holding slot
  assign rx_ev     = rx_done && !rx_full;
  assign rx_ovr_ev = rx_done && rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_data <= '0;
    end else if (rx_ev) begin
      rx_full <= 1'b1;
      rx_data <= rx_byte;
    end else if (bus_rd && sel_data) begin
      rx_full <= 1'b0;
    end
  end

  // sticky flags, set wins over clear
  assign fl_set = {rx_ovr_ev, tx_ovr_ev, rx_ev, tx_take};
  assign fl_clr = ((bus_wr && sel_ints) ? bus_wdata[FLAG_W-1:0] : '0)
                | ((bus_wr && sel_stat) ? {bus_wdata[F_RXO:F_TXO], 2'b00} : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~fl_clr) | fl_set;
  end

  assign irq_tx  = flags_q[F_TX] && ctrl_q[C_TX_IE];
  assign irq_rx  = flags_q[F_RX] && ctrl_q[C_RX_IE];
  assign irq_ovr = (flags_q[F_TXO] && ctrl_q[C_TXO_IE])
                || (flags_q[F_RXO] && ctrl_q[C_RXO_IE]);

  always_comb begin
    bus_rdata = '0;
    if (sel_data)      bus_rdata = BUS_W'(rx_data);
    else if (sel_stat) bus_rdata = BUS_W'({flags_q[F_RXO], flags_q[F_TXO], rx_full, hold_full});
    else if (sel_ctrl) bus_rdata = BUS_W'(ctrl_q);
    else if (sel_ints) bus_rdata = BUS_W'(flags_q);
    else if (sel_div)  bus_rdata = BUS_W'(div_q);
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker import sp_pkg::*; (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic                 wbit_rx,
  input logic                 sel_data,
  input logic                 sel_ints,
  input logic                 txd,
  input logic [CTRL_W-1:0]    ctrl_q,
  input logic [FLAG_W-1:0]    flags_q,
  input logic                 hold_full,
  input logic                 rx_full,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 tx_take,
  input logic                 rx_done
);
  AST_TAKE_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !txd); // R3
  AST_TX_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_data && hold_full && ctrl_q[C_TX_EN]) |=> flags_q[F_TXO]); // R5
  AST_READ_EMPTIES_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_data && !rx_done) |=> !rx_full); // R7
  AST_RX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full) |=> ($stable(rx_data) && flags_q[F_RXO])); // R8
  AST_W1C_RX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ints && wbit_rx && !rx_done) |=> !flags_q[F_RX]); // R9
  AST_TX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[C_TX_EN] |=> txd); // R11
endmodule

bind serial_port_core sp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .wbit_rx(bus_wdata[1]), .sel_data(sel_data), .sel_ints(sel_ints),
  .txd(txd), .ctrl_q(ctrl_q), .flags_q(flags_q), .hold_full(hold_full),
  .rx_full(rx_full), .rx_data(rx_data), .tx_take(tx_take), .rx_done(rx_done)
);

// File: tb/sim_serial_port_core.sv
`timescale 1ns/1ps
module sim_serial_port_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rxd = 1'b1;
  logic        txd, irq_rx, irq_tx, irq_ovr;

  int errs = 0;
  int checks = 0;
  bit run = 0;

  always #2.5 clk = ~clk;

  serial_port_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .rxd(rxd), .txd(txd),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ovr(irq_ovr)
  );

  // behavioural transmit model, time-based
  longint    cyc = 0;
  bit [5:0]  m_ctrl = '0;
  int        m_div = 0;
  int        m_hold = -1;
  longint    m_start = -1;
  bit [9:0]  m_frame = '1;
  int        m_eff = 16;
  bit        m_txflag = 0, m_txovr = 0, m_txd = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_div = 0; m_hold = -1; m_start = -1;
      m_txflag = 0; m_txovr = 0; m_txd = 1;
    end else begin
      int  hb, eff;
      bit  busy, take, ovr;
      cyc = cyc + 1;
      eff = (m_div < 16) ? 16 : m_div;
      hb = m_hold;
      busy = (m_start >= 0) && (cyc <= m_start + 10 * m_eff);
      take = 0; ovr = 0;
      if (!m_ctrl[0]) begin
        m_start = -1; m_hold = -1;
      end else if (!busy && hb >= 0) begin
        take = 1; m_start = cyc; m_eff = eff;
        m_frame = {1'b1, 8'(hb), 1'b0}; m_hold = -1;
      end
      if (wr && addr[4:2] == 0 && m_ctrl[0]) begin
        if (hb >= 0) ovr = 1;
        else m_hold = int'(wdata[7:0]);
      end
      if (wr && addr[4:2] == 3) begin
        if (wdata[0]) m_txflag = 0;
        if (wdata[2]) m_txovr = 0;
      end
      if (wr && addr[4:2] == 1 && wdata[2]) m_txovr = 0;
      if (take) m_txflag = 1;
      if (ovr) m_txovr = 1;
      if (wr && addr[4:2] == 2) m_ctrl = wdata[5:0];
      if (wr && addr[4:2] == 4) m_div = int'(wdata[20:0]);
      if (m_start >= 0 && cyc - m_start < 10 * m_eff)
        m_txd = m_frame[int'((cyc - m_start) / m_eff)];
      else
        m_txd = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && run) begin
      chk(txd === m_txd, "R3 txd line", 32'(txd), 32'(m_txd));
      chk(irq_tx === (m_txflag & m_ctrl[2]), "R4 irq_tx", 32'(irq_tx), 32'(m_txflag & m_ctrl[2]));
    end
  end

  task automatic wr_reg(input int idx, input logic [31:0] v);
    addr = 5'(idx * 4); wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] v);
    addr = 5'(idx * 4); rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input int eff);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd = f[i];
      repeat (eff) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rd_reg(i, v);
      chk(v == 0, "R1 register zero", v, 0);
    end
    chk(txd === 1'b1 && irq_rx === 1'b0 && irq_tx === 1'b0 && irq_ovr === 1'b0,
        "R1 outputs idle", {txd, irq_rx, irq_tx, irq_ovr}, 32'h8);

    // R2 register map and widths
    wr_reg(2, 32'hFFFF_FFFF); rd_reg(2, v);
    chk(v == 32'h3F, "R2 ctrl width", v, 32'h3F);
    wr_reg(4, 32'hFFFF_FFFF); rd_reg(4, v);
    chk(v == 32'h1F_FFFF, "R2 divider width", v, 32'h1F_FFFF);
    rd_reg(7, v);
    chk(v == 0, "R2 unused index", v, 0);
    wr_reg(4, 20);
    wr_reg(2, 32'h3F);

    // R3 R4 single byte
    wr_reg(0, 32'hA5); rd_reg(1, v);
    chk(v[0] == 1'b1, "R4 tx full while held", v, 1);
    rd_reg(1, v);
    chk(v[0] == 1'b0, "R4 tx full clears on take", v, 0);
    idle(210);
    rd_reg(3, v);
    chk(v[0] == 1'b1 && irq_tx, "R4 tx flag", v, 1);
    wr_reg(3, 32'h1); rd_reg(3, v);
    chk(v[0] == 1'b0, "R9 tx flag cleared", v, 0);

    // R5 overrun on full slot
    wr_reg(0, 32'h11); idle(3);
    wr_reg(0, 32'h22); wr_reg(0, 32'h33);
    rd_reg(1, v);
    chk(v[2] == 1'b1, "R5 status overrun", v, 4);
    rd_reg(3, v);
    chk(v[2] == 1'b1 && irq_ovr, "R5 flag and irq_ovr", v, 4);
    idle(420);
    wr_reg(1, 32'h4); rd_reg(3, v);
    chk(v[2] == 1'b0 && !irq_ovr, "R9 clear via status", v, 0);
    wr_reg(3, 32'h1);

    // R6 receive
    send_frame(8'h3C, 20); idle(3);
    rd_reg(1, v);
    chk(v[1] == 1'b1, "R6 rx full", v, 2);
    rd_reg(3, v);
    chk(v[1] == 1'b1 && irq_rx, "R6 rx flag and irq", v, 2);
    // R9 write zero keeps flag
    wr_reg(3, 32'h0); rd_reg(3, v);
    chk(v[1] == 1'b1, "R9 zero write keeps", v, 2);
    wr_reg(3, 32'h2); rd_reg(3, v);
    chk(v[1] == 1'b0 && !irq_rx, "R9 rx flag cleared", v, 0);

    // R8 overrun on unread slot
    send_frame(8'h81, 20); idle(3);
    rd_reg(3, v);
    chk(v[3] == 1'b1 && irq_ovr, "R8 rx overrun flag", v, 8);
    chk(v[1] == 1'b0, "R8 no new rx flag", v, 8);
    // R7 destructive read keeps old byte
    rd_reg(0, v);
    chk(v == 32'h3C, "R8 data kept", v, 32'h3C);
    rd_reg(1, v);
    chk(v[1] == 1'b0, "R7 read clears full", v, 0);
    wr_reg(3, 32'h8);

    // R12 glitch and rx disable
    rxd = 1'b0; idle(4); rxd = 1'b1; idle(300);
    rd_reg(1, v);
    chk(v[1] == 1'b0, "R12 glitch rejected", v, 0);
    wr_reg(2, 32'h3D);
    send_frame(8'h5A, 20); idle(3);
    rd_reg(1, v);
    chk(v[1] == 1'b0, "R12 rx disabled", v, 0);
    wr_reg(2, 32'h3F);

    // R10 divider clamp
    wr_reg(4, 4); rd_reg(4, v);
    chk(v == 4, "R10 readback", v, 4);
    wr_reg(0, 32'hC3);
    send_frame(8'h96, 16); idle(3);
    rd_reg(0, v);
    chk(v == 32'h96, "R10 rx at clamped rate", v, 32'h96);
    idle(40);
    wr_reg(3, 32'hF);

    // R11 abort and ignored writes
    wr_reg(0, 32'h0F); idle(50);
    wr_reg(2, 32'h3E); idle(1);
    chk(txd === 1'b1, "R11 line idle after abort", 32'(txd), 1);
    wr_reg(0, 32'h77); rd_reg(1, v);
    chk(v[0] == 1'b0 && v[2] == 1'b0, "R11 write ignored", v, 0);
    wr_reg(2, 32'h3F); idle(30);
    chk(txd === 1'b1, "R11 nothing sent after re-enable", 32'(txd), 1);

    run = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule